// File: doc/BRIEF.md
# Selectable Fixed-Point Requantizer

This block takes one wide fixed-point sample and re-expresses it in a narrower fixed-point format. The input format has a total width and a fractional width set by parameters. The output format has its own total width and fractional width. A parameter chooses between a signed and an unsigned interpretation, and signed is the default. The block sits between two datapath stages. Each sample carries a 2-bit mode that picks the policy for both ends of the value:

- at the low end, the bits below the output LSB are either truncated (floor) or rounded by adding half an output LSB first;
- at the high end, an out-of-range result either wraps, keeping only its low bits, or saturates to the nearest limit of the output format.

If the output has more fractional bits than the input, the value is shifted left with zero fill, and rounding has no effect.

Samples enter and leave on valid/ready streams. A sample is accepted in a cycle where both `in_valid` and `in_ready` are high. A result is taken in a cycle where both `out_valid` and `out_ready` are high.

The parameter `REG_EN` selects whether the output is registered:

- With `REG_EN=1`, a single output register holds the result. Back-pressure works as follows: `in_ready` is high when the register is empty or when it is being drained in the same cycle. A result that is stalled holds its data and flag unchanged until it is taken.
- With `REG_EN=0`, the path is purely combinational. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

An overflow flag travels with each result. It is high only when saturation changed the value.

Top module: `rq_requant`

## Requirements
- R1: Mode 2'b00 floors the value to the output LSB and keeps only the low OUT_W bits of the result (wrap).
- R2: Mode 2'b01 adds half an output LSB before flooring, then wraps like R1.
- R3: Mode 2'b10 floors the value, then clamps an out-of-range signed result to 0 followed by all ones (most positive) or 1 followed by all zeros (most negative).
- R4: Mode 2'b11 rounds as in R2 and then clamps as in R3. A carry produced by rounding counts toward the overflow test, so 0x07F8 in the default format (8 fraction bits in, 4 out) gives 0x7F with the flag set.
- R5: `out_ovf` is 1 exactly when clamping changed the value. It is always 0 in the wrap modes 2'b00 and 2'b01.
- R6: With an unsigned format, clamping produces all ones on overflow. Zero is the lower limit.
- R7: When the output has more fractional bits than the input, the value is zero-extended on the right and rounding has no effect.
- R8: After reset `out_valid` is 0 and `in_ready` is 1.
- R9: With `REG_EN=1`, `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_data` and `out_ovf` stay stable.
- R10: Each accepted sample yields exactly one result, and results leave in the order their samples were accepted.
- R11: With `REG_EN=0`, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the result appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | IN_W | Input fixed-point sample |
| in_mode | input | 2 | Bit 0 selects rounding, bit 1 selects clamping |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | OUT_W | Requantized result |
| out_ovf | output | 1 | Clamping altered this result |

## Verification
The hardest case to reach from the ports is an overflow caused only by the rounding carry. In that case the floored value fits the output format, but the rounded value does not. The stimulus reaches it by feeding inputs sitting just below the positive and negative limits: 0x07F8, 0x07F7 and 0xF808. Each of these is applied under all four modes. A random phase then toggles `out_ready` while new samples keep arriving, so that results are stalled while new inputs are offered. Stability and ordering are checked during these stalls.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    RQ_TRUNC_WRAP = 2'b00,
    RQ_ROUND_WRAP = 2'b01,
    RQ_TRUNC_CLIP = 2'b10,
    RQ_ROUND_CLIP = 2'b11
  } rq_mode_e;

  function automatic logic rq_rounds(rq_mode_e m);
    return m inside {RQ_ROUND_WRAP, RQ_ROUND_CLIP};
  endfunction

  function automatic logic rq_clips(rq_mode_e m);
    return m inside {RQ_TRUNC_CLIP, RQ_ROUND_CLIP};
  endfunction
endpackage

// File: rtl/rq_align.sv
// Moves the binary point of the input to the output position.
// The result is one bit wider than needed, so a rounding carry is never lost.
module rq_align #(
  parameter int IN_W   = 16,
  parameter int IN_F   = 8,
  parameter int OUT_F  = 4,
  parameter bit SIGNED = 1'b1,
  localparam int RSH   = (IN_F > OUT_F) ? IN_F - OUT_F : 0,
  localparam int LSH   = (OUT_F > IN_F) ? OUT_F - IN_F : 0,
  localparam int AW    = IN_W + LSH + 1
) (
  input  logic [IN_W-1:0] x,
  input  logic            rnd,
  output logic [AW-1:0]   v
);
  logic sbit;
  assign sbit = SIGNED ? x[IN_W-1] : 1'b0;

  generate
    if (RSH > 0) begin : g_drop
      logic [AW-1:0] ext, half, sum;
      always_comb begin
        ext  = {sbit, x};
        half = AW'(1) << (RSH - 1);
        sum  = ext + (rnd ? half : '0);
        if (SIGNED) v = AW'($signed(sum) >>> RSH);
        else        v = sum >> RSH;
      end
    end else if (LSH > 0) begin : g_extend
      // rounding is meaningless here: no bits are dropped
      logic unused_rnd;
      assign unused_rnd = rnd;
      assign v = {sbit, x, {LSH{1'b0}}};
    end else begin : g_same
      logic unused_rnd;
      assign unused_rnd = rnd;
      assign v = {sbit, x};
    end
  endgenerate
endmodule

// File: rtl/rq_limit.sv
// Range test plus either saturation or wrap-around.
module rq_limit #(
  parameter int VW     = 17,
  parameter int OUT_W  = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic [VW-1:0]    v,
  input  logic             clip,
  output logic [OUT_W-1:0] y,
  output logic             ovf
);
  logic             fits;
  logic [OUT_W-1:0] sat;

  generate
    if (SIGNED) begin : g_s
      logic [VW-OUT_W:0] top;
      assign top  = v[VW-1:OUT_W-1];
      assign fits = (&top) | ~(|top);
      assign sat  = v[VW-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                            : {1'b0, {(OUT_W-1){1'b1}}};
    end else begin : g_u
      // the aligned value is never negative, so only the upper limit is reachable
      assign fits = ~(|v[VW-1:OUT_W]);
      assign sat  = v[VW-1] ? {OUT_W{1'b0}} : {OUT_W{1'b1}};
    end
  endgenerate

  always_comb begin
    ovf = clip & ~fits;
    y   = ovf ? sat : v[OUT_W-1:0];
  end
endmodule

// File: rtl/rq_stage.sv
// Optional one-entry output register on a valid/ready stream.
module rq_stage #(
  parameter int W      = 9,
  parameter bit REG_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  generate
    if (REG_EN) begin : g_reg
      logic         full;
      logic [W-1:0] held;
      assign s_ready = ~full | m_ready;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full <= 1'b0;
          held <= '0;
        end else if (s_valid && s_ready) begin
          full <= 1'b1;
          held <= s_data;
        end else if (m_ready) begin
          full <= 1'b0;
        end
      end
      assign m_valid = full;
      assign m_data  = held;
    end else begin : g_thru
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign m_valid = s_valid;
      assign s_ready = m_ready;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/rq_requant.sv
module rq_requant
  import rq_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int IN_F   = 8,
  parameter int OUT_W  = 8,
  parameter int OUT_F  = 4,
  parameter bit SIGNED = 1'b1,
  parameter bit REG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);
  localparam int LSH = (OUT_F > IN_F) ? OUT_F - IN_F : 0;
  localparam int AW  = IN_W + LSH + 1;
  localparam int LW  = (AW > OUT_W) ? AW : OUT_W + 1;

  rq_mode_e         mode;
  logic [AW-1:0]    aligned;
  logic [LW-1:0]    widened;
  logic [OUT_W-1:0] lim_y;
  logic             lim_ovf;
  logic [OUT_W:0]   packed_q;

  assign mode = rq_mode_e'(in_mode);

  rq_align #(.IN_W(IN_W), .IN_F(IN_F), .OUT_F(OUT_F), .SIGNED(SIGNED)) u_align (
    .x(in_data), .rnd(rq_rounds(mode)), .v(aligned)
  );

  generate
    if (LW > AW) begin : g_wide
      assign widened = {{(LW-AW){SIGNED ? aligned[AW-1] : 1'b0}}, aligned};
    end else begin : g_keep
      assign widened = aligned;
    end
  endgenerate

  rq_limit #(.VW(LW), .OUT_W(OUT_W), .SIGNED(SIGNED)) u_limit (
    .v(widened), .clip(rq_clips(mode)), .y(lim_y), .ovf(lim_ovf)
  );

  rq_stage #(.W(OUT_W + 1), .REG_EN(REG_EN)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data({lim_ovf, lim_y}),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(packed_q)
  );

  assign out_data = packed_q[OUT_W-1:0];
  assign out_ovf  = packed_q[OUT_W];
endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int OUT_W  = 8,
  parameter bit SIGNED = 1'b1,
  parameter bit REG_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_ovf
);
  generate
    if (SIGNED) begin : g_s
      p_sat_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |->
          (out_data == {1'b0, {(OUT_W-1){1'b1}}} || out_data == {1'b1, {(OUT_W-1){1'b0}}}));
    end else begin : g_u
      p_sat_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |-> out_data == {OUT_W{1'b1}});
    end

    if (REG_EN) begin : g_reg
      p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf));
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_mode[1] |=> !out_ovf);
      p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    end else begin : g_thru
      p_pass_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid && in_ready == out_ready);
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_mode[1] |-> !out_ovf);
    end
  endgenerate
endmodule

bind rq_requant rq_requant_chk #(.OUT_W(OUT_W), .SIGNED(SIGNED), .REG_EN(REG_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/sim_rq_requant.sv
`timescale 1ns/1ps
module sim_rq_requant;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        out_ready = 1'b0;

  logic       rdy0, vld0, ovf0;
  logic [7:0] dat0;
  logic       rdy1, vld1, ovf1;
  logic [7:0] dat1;
  logic       rdy2, vld2, ovf2;
  logic [7:0] dat2;

  // signed 16.8 -> 8.4, registered
  rq_requant u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_data(in_data), .in_mode(in_mode), .out_valid(vld0), .out_ready(out_ready),
    .out_data(dat0), .out_ovf(ovf0));
  // unsigned 16.8 -> 8.4, combinational
  rq_requant #(.SIGNED(1'b0), .REG_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(rdy1), .in_data(in_data), .in_mode(in_mode),
    .out_valid(vld1), .out_ready(out_ready), .out_data(dat1), .out_ovf(ovf1));
  // signed 8.2 -> 8.4, combinational
  rq_requant #(.IN_W(8), .IN_F(2), .OUT_W(8), .OUT_F(4), .REG_EN(1'b0)) u2 (.clk(clk),
    .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2), .in_data(in_data[7:0]),
    .in_mode(in_mode), .out_valid(vld2), .out_ready(out_ready), .out_data(dat2),
    .out_ovf(ovf2));

  int checks = 0;
  int fails  = 0;
  logic [8:0] expq[$];
  string      tagq[$];
  bit   stalled = 0;
  logic [8:0] stall_val;

  function automatic logic [8:0] model(int x, int rsh, int lsh, bit rnd, bit clip, bit sgn);
    int v, hi, lo;
    logic [8:0] r;
    if (rsh > 0) v = (x + (rnd ? (1 <<< (rsh - 1)) : 0)) >>> rsh;
    else         v = x <<< lsh;
    hi = sgn ? 127 : 255;
    lo = sgn ? -128 : 0;
    r = {1'b0, v[7:0]};
    if (clip && v > hi)      r = {1'b1, hi[7:0]};
    else if (clip && v < lo) r = {1'b1, lo[7:0]};
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // observe handshakes that occur at the next rising edge
  task automatic observe();
    logic [8:0] e0, e1, e2;
    #1;
    // R9: ready rule and hold under stall
    check(rdy0 == (!vld0 || out_ready), "R9", {15'd0, rdy0}, {15'd0, (!vld0 || out_ready)});
    if (stalled) check(vld0 && {ovf0, dat0} == stall_val, "R9", {7'd0, ovf0, dat0}, {7'd0, stall_val});
    stalled = vld0 && !out_ready;
    stall_val = {ovf0, dat0};
    if (vld0 && out_ready) begin
      if (expq.size() == 0) check(1'b0, "R10", {7'd0, ovf0, dat0}, 16'hxxxx);
      else begin
        e0 = expq.pop_front();
        check({ovf0, dat0} == e0, (e0[8] != ovf0) ? "R5" : tagq.pop_front(),
              {7'd0, ovf0, dat0}, {7'd0, e0});
      end
    end
    if (in_valid && rdy0) begin
      expq.push_back(model(int'($signed(in_data)), 4, 0, in_mode[0], in_mode[1], 1'b1));
      tagq.push_back(mode_tag(in_mode));
    end
    // R11: pass-through instances
    check(vld1 == in_valid && rdy1 == out_ready && vld2 == in_valid && rdy2 == out_ready,
          "R11", {12'd0, vld1, rdy1, vld2, rdy2}, {12'd0, in_valid, out_ready, in_valid, out_ready});
    if (in_valid) begin
      e1 = model(int'(in_data), 4, 0, in_mode[0], in_mode[1], 1'b0);
      check({ovf1, dat1} == e1, "R6", {7'd0, ovf1, dat1}, {7'd0, e1});
      e2 = model(int'($signed(in_data[7:0])), 0, 2, in_mode[0], in_mode[1], 1'b1);
      check({ovf2, dat2} == e2, "R7", {7'd0, ovf2, dat2}, {7'd0, e2});
    end
  endtask

  task automatic step(bit v, logic [15:0] d, logic [1:0] m, bit r);
    @(negedge clk);
    in_valid = v; in_data = d; in_mode = m; out_ready = r;
    observe();
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [15:0] corners [10] = '{16'h07F8, 16'h07F7, 16'hF808, 16'hF807, 16'h8000,
                                16'h7FFF, 16'h0000, 16'h0018, 16'hFFE8, 16'h001F};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vld0 && rdy0, "R8", {14'd0, vld0, rdy0}, 16'h0001);
    rst_n = 1'b1;
    // directed corners in every mode, no stalls
    foreach (corners[i]) begin
      for (int m = 0; m < 4; m++) step(1'b1, corners[i], 2'(m), 1'b1);
    end
    // rounding carry into overflow: 0x07F8 rounds to 128 -> clamp to 0x7F
    step(1'b1, 16'h07F8, 2'b11, 1'b1);
    step(1'b0, 16'h0000, 2'b00, 1'b1);
    check(vld0 && dat0 == 8'h7F && ovf0, "R4", {7'd0, ovf0, dat0}, 16'h017F);
    // random traffic with back-pressure
    for (int k = 0; k < 3000; k++)
      step(1'($urandom_range(0, 3) != 0), 16'($urandom), 2'($urandom), 1'($urandom_range(0, 2) != 0));
    // drain
    for (int k = 0; k < 4; k++) step(1'b0, 16'h0000, 2'b00, 1'b1);
    check(expq.size() == 0 && !vld0, "R10", 16'(expq.size()), 16'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule